// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides the power state of a small 8-bit controller. Software writes two mode-select bits and a one-way lock bit through a narrow configuration port. When the CPU issues its idle-instruction strobe, the block moves from RUN into one of three reduced states: plain IDLE (only the CPU stops), STANDBY (the CPU and peripheral clocks stop, while the oscillator and timer keep running) or HALT (everything stops, including the oscillator). Qualified wake requests bring it back. Reset always returns it to RUN. There are three external interrupts and one timer interrupt. Each reduced state accepts its own set of these as wake sources.

A mask-option input can disable the STANDBY and HALT states completely. A hard-watchdog option input makes external interrupt 0 wake STANDBY or HALT even when its enable flag is clear. On a wake from HALT, the block passes through a RESTART state. In RESTART it requests clock restart and holds the CPU stopped for a fixed number of cycles while the oscillator settles.

States: RUN, IDLE, STANDBY, HALT, RESTART.

Transitions:
- RUN→IDLE, RUN→STANDBY and RUN→HALT happen on the idle strobe when no wake request for the target state is pending.
- IDLE→RUN and STANDBY→RUN happen on a wake request from that state's set.
- HALT→RESTART happens on a HALT wake request.
- RESTART→RUN happens when the settle count expires.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the state is RUN (code 0), all three configuration bits read 0, and the outputs show the RUN profile.
- R2: A configuration write (`cfg_wr`) loads bit 0 as the power-down bit, bit 1 as the halt-select bit and bit 2 as the lock bit. `cfg_rdata` returns the three bits in the same positions.
- R3: A write can set the lock bit only while the lock bit is 0. Once the lock bit is 1, it stays 1 until reset and later writes change none of the three bits.
- R4: While `opt_lp_disable` is 1, writes leave both mode bits unchanged, and the idle strobe selects IDLE whatever the mode bits hold.
- R5: The idle strobe in RUN selects the target state from the mode bits:
  - power-down 0 selects IDLE (code 1);
  - power-down 1 with halt-select 0 selects STANDBY (code 2);
  - power-down 1 with halt-select 1 selects HALT (code 3).
  RESTART is code 4. The state code appears on `pwr_state` one clock after the deciding edge.
- R6: Each state drives a fixed output profile, given as {cpu_stop, periph_clk_en, tmr_clk_en, osc_stop, wd_clk_inhibit, clk_restart}:
  - RUN: 011000
  - IDLE: 111000
  - STANDBY: 101010
  - HALT: 100110
  - RESTART: 100011
- R7: IDLE returns to RUN on any external interrupt whose enable bit is set, or on the timer interrupt. An external interrupt with its enable bit clear is ignored.
- R8: STANDBY returns to RUN on an enabled external interrupt or on the timer interrupt.
- R9: HALT wakes only on an enabled external interrupt. The timer interrupt leaves HALT unchanged.
- R10: With `opt_hard_wd` at 1, external interrupt 0 wakes STANDBY and HALT regardless of its enable bit. It does not wake IDLE unless its enable bit is set.
- R11: If a wake request from the target state's set is already present when the idle strobe arrives, the block stays in RUN.
- R12: A wake from HALT enters RESTART. `clk_restart` is then high for exactly RESTART_CYCLES clocks, after which the state is RUN.
- R13: The idle strobe has no effect in any state other than RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Write data: bit 0 power-down, bit 1 halt-select, bit 2 lock |
| cfg_rdata | output | 3 | Current configuration bits, in the same positions |
| opt_lp_disable | input | 1 | Mask option that disables STANDBY and HALT |
| opt_hard_wd | input | 1 | Hard-watchdog option that forces external interrupt 0 as a wake source |
| idle_stb | input | 1 | Idle-instruction strobe from the CPU |
| ext_irq | input | NUM_EXT | Qualified external interrupt requests |
| ext_irq_en | input | NUM_EXT | Per-interrupt enable flags |
| tmr_irq | input | 1 | Qualified timer interrupt request |
| pwr_state | output | 3 | Current state code |
| cpu_stop | output | 1 | Stops the CPU |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| tmr_clk_en | output | 1 | General-purpose timer clock enable |
| osc_stop | output | 1 | Stops the oscillator and internal clocks |
| wd_clk_inhibit | output | 1 | Inhibits the watchdog clock |
| clk_restart | output | 1 | Clock restart request during oscillator settling |

## Verification
The assertions check a set of cycle-level rules on every cycle:
- the lock bit never clears;
- mode bits never change while locked or while low-power modes are disabled;
- the disable option always steers the idle strobe to IDLE;
- the timer interrupt never moves HALT;
- a HALT wake always raises clock restart with the CPU still stopped;
- the settle counter stays in range.

The bench's reference model compares the full state and output profile on every clock. Only the directed scenarios show the following:
- the exact length of the restart window;
- the pending-wake refusal at the idle strobe;
- the forced external interrupt 0 under the hard-watchdog option;
- that stray idle strobes and disabled interrupts leave each reduced state untouched.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int CFG_W        = 3;
    localparam int CFG_PD_BIT   = 0;
    localparam int CFG_HS_BIT   = 1;
    localparam int CFG_LOCK_BIT = 2;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_IDLE    = 3'd1,
        PS_STANDBY = 3'd2,
        PS_HALT    = 3'd3,
        PS_RESTART = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        LM_IDLE    = 2'd0,
        LM_STANDBY = 2'd1,
        LM_HALT    = 2'd2
    } lp_mode_e;

    typedef struct packed {
        logic cpu_stop;
        logic periph_en;
        logic tmr_en;
        logic osc_stop;
        logic wd_inh;
        logic restart;
    } clk_prof_t;

endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             lp_disable,
    output logic [CFG_W-1:0] rdata,
    output lp_mode_e         sel_mode
);

    logic pd_q;
    logic hs_q;
    logic lock_q;
    logic wr_ok;

    assign wr_ok = wr && !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q   <= 1'b0;
            hs_q   <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr_ok) begin
            if (!lp_disable) begin
                pd_q <= wdata[CFG_PD_BIT];
                hs_q <= wdata[CFG_HS_BIT];
            end
            lock_q <= wdata[CFG_LOCK_BIT];
        end
    end

    always_comb begin
        rdata               = '0;
        rdata[CFG_PD_BIT]   = pd_q;
        rdata[CFG_HS_BIT]   = hs_q;
        rdata[CFG_LOCK_BIT] = lock_q;
    end

    always_comb begin
        if (lp_disable || !pd_q) begin
            sel_mode = LM_IDLE;
        end else if (hs_q) begin
            sel_mode = LM_HALT;
        end else begin
            sel_mode = LM_STANDBY;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R3

    AST_LOCKED_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable({pd_q, hs_q})); // R3

    AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        lp_disable |=> $stable({pd_q, hs_q})); // R4

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NUM_EXT = 3
) (
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_EXT-1:0] ext_irq_en,
    input  logic               tmr_irq,
    input  logic               hard_wd,
    output logic               wake_idle,
    output logic               wake_stby,
    output logic               wake_halt
);

    logic [NUM_EXT-1:0] ext_q;
    logic [NUM_EXT-1:0] ext_lp;

    assign ext_q = ext_irq & ext_irq_en;

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
            if (i == 0) begin : g_forced
                assign ext_lp[i] = ext_q[i] | (hard_wd & ext_irq[i]);
            end else begin : g_plain
                assign ext_lp[i] = ext_q[i];
            end
        end
    endgenerate

    assign wake_idle = (|ext_q) | tmr_irq;
    assign wake_stby = (|ext_lp) | tmr_irq;
    assign wake_halt = |ext_lp;

    always_comb begin
        AST_HALT_SET_SUBSET: assert (!wake_halt || wake_stby); // R9
    end

endmodule

// File: rtl/lpm_restart_timer.sv
module lpm_restart_timer #(
    parameter int RESTART_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (RESTART_CYCLES < 2) ? 1 : $clog2(RESTART_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RESTART_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R12

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_EXT        = 3,
    parameter int RESTART_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_wdata,
    output logic [2:0]         cfg_rdata,
    input  logic               opt_lp_disable,
    input  logic               opt_hard_wd,
    input  logic               idle_stb,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_EXT-1:0] ext_irq_en,
    input  logic               tmr_irq,
    output logic [2:0]         pwr_state,
    output logic               cpu_stop,
    output logic               periph_clk_en,
    output logic               tmr_clk_en,
    output logic               osc_stop,
    output logic               wd_clk_inhibit,
    output logic               clk_restart
);

    pwr_state_e state_q;
    pwr_state_e state_d;
    lp_mode_e   sel_mode;
    logic       wake_idle;
    logic       wake_stby;
    logic       wake_halt;
    logic       settle_done;
    clk_prof_t  prof;

    lpm_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .wdata      (cfg_wdata),
        .lp_disable (opt_lp_disable),
        .rdata      (cfg_rdata),
        .sel_mode   (sel_mode)
    );

    lpm_wake_qual #(.NUM_EXT(NUM_EXT)) u_wake (
        .ext_irq    (ext_irq),
        .ext_irq_en (ext_irq_en),
        .tmr_irq    (tmr_irq),
        .hard_wd    (opt_hard_wd),
        .wake_idle  (wake_idle),
        .wake_stby  (wake_stby),
        .wake_halt  (wake_halt)
    );

    lpm_restart_timer #(.RESTART_CYCLES(RESTART_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == PS_RESTART),
        .done  (settle_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (idle_stb) begin
                    unique case (sel_mode)
                        LM_IDLE:    if (!wake_idle) state_d = PS_IDLE;
                        LM_STANDBY: if (!wake_stby) state_d = PS_STANDBY;
                        LM_HALT:    if (!wake_halt) state_d = PS_HALT;
                        default:    state_d = PS_RUN;
                    endcase
                end
            end
            PS_IDLE:    if (wake_idle)   state_d = PS_RUN;
            PS_STANDBY: if (wake_stby)   state_d = PS_RUN;
            PS_HALT:    if (wake_halt)   state_d = PS_RESTART;
            PS_RESTART: if (settle_done) state_d = PS_RUN;
            default:    state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        prof = '{cpu_stop: 1'b0, periph_en: 1'b1, tmr_en: 1'b1,
                 osc_stop: 1'b0, wd_inh: 1'b0, restart: 1'b0};
        unique case (state_q)
            PS_RUN: ;
            PS_IDLE: prof.cpu_stop = 1'b1;
            PS_STANDBY: begin
                prof.cpu_stop  = 1'b1;
                prof.periph_en = 1'b0;
                prof.wd_inh    = 1'b1;
            end
            PS_HALT: begin
                prof.cpu_stop  = 1'b1;
                prof.periph_en = 1'b0;
                prof.tmr_en    = 1'b0;
                prof.osc_stop  = 1'b1;
                prof.wd_inh    = 1'b1;
            end
            PS_RESTART: begin
                prof.cpu_stop  = 1'b1;
                prof.periph_en = 1'b0;
                prof.tmr_en    = 1'b0;
                prof.wd_inh    = 1'b1;
                prof.restart   = 1'b1;
            end
            default: ;
        endcase
    end

    assign pwr_state      = state_q;
    assign cpu_stop       = prof.cpu_stop;
    assign periph_clk_en  = prof.periph_en;
    assign tmr_clk_en     = prof.tmr_en;
    assign osc_stop       = prof.osc_stop;
    assign wd_clk_inhibit = prof.wd_inh;
    assign clk_restart    = prof.restart;

    AST_DISABLE_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && idle_stb && opt_lp_disable && !wake_idle)
        |=> (pwr_state == 3'd1)); // R4

    AST_HALT_ENTRY_STOPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && idle_stb && sel_mode == LM_HALT && !wake_halt)
        |=> (osc_stop && !tmr_clk_en)); // R5

    AST_TMR_NO_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HALT && !wake_halt) |=> (pwr_state == 3'd3)); // R9

    AST_HALT_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HALT && wake_halt) |=> (clk_restart && cpu_stop && !osc_stop)); // R12

    AST_STRAY_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STANDBY && !wake_stby) |=> (pwr_state == 3'd2)); // R13

endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;

    localparam int RC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [2:0] cfg_rdata;
    logic       opt_lp_disable = 1'b0;
    logic       opt_hard_wd = 1'b0;
    logic       idle_stb = 1'b0;
    logic [2:0] ext_irq = '0;
    logic [2:0] ext_irq_en = '0;
    logic       tmr_irq = 1'b0;
    logic [2:0] pwr_state;
    logic       cpu_stop, periph_clk_en, tmr_clk_en, osc_stop, wd_clk_inhibit, clk_restart;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.NUM_EXT(3), .RESTART_CYCLES(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .opt_lp_disable(opt_lp_disable),
        .opt_hard_wd(opt_hard_wd), .idle_stb(idle_stb), .ext_irq(ext_irq),
        .ext_irq_en(ext_irq_en), .tmr_irq(tmr_irq), .pwr_state(pwr_state),
        .cpu_stop(cpu_stop), .periph_clk_en(periph_clk_en), .tmr_clk_en(tmr_clk_en),
        .osc_stop(osc_stop), .wd_clk_inhibit(wd_clk_inhibit), .clk_restart(clk_restart)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: states 0 run,1 idle,2 standby,3 halt,4 restart
    int m_st, m_cnt;
    bit m_pd, m_hs, m_lock;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pd = 0; m_hs = 0; m_lock = 0;
        end else begin
            int ns;
            bit wi, ws, wh, anyen;
            ns = m_st;
            anyen = (ext_irq & ext_irq_en) != 0;
            wi = anyen || tmr_irq;
            wh = anyen || (opt_hard_wd && ext_irq[0]);
            ws = wh || tmr_irq;
            case (m_st)
                0: if (idle_stb) begin
                       if (opt_lp_disable || !m_pd) begin if (!wi) ns = 1; end
                       else if (!m_hs) begin if (!ws) ns = 2; end
                       else if (!wh) ns = 3;
                   end
                1: if (wi) ns = 0;
                2: if (ws) ns = 0;
                3: if (wh) begin ns = 4; m_cnt = 0; end
                4: if (m_cnt == RC - 1) ns = 0; else m_cnt++;
                default: ns = 0;
            endcase
            if (cfg_wr && !m_lock) begin
                if (!opt_lp_disable) begin m_pd = cfg_wdata[0]; m_hs = cfg_wdata[1]; end
                m_lock = cfg_wdata[2];
            end
            m_st = ns;
        end
    end

    function automatic int prof_of(input int st);
        case (st)
            0: return 6'b011000;
            1: return 6'b111000;
            2: return 6'b101010;
            3: return 6'b100110;
            default: return 6'b100011;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 state per cycle", int'(pwr_state), m_st);
            chk("R6 profile per cycle",
                int'({cpu_stop, periph_clk_en, tmr_clk_en, osc_stop, wd_clk_inhibit, clk_restart}),
                prof_of(m_st));
            chk("R2 readback per cycle", int'(cfg_rdata), int'({m_lock, m_hs, m_pd}));
        end
    end

    task automatic do_reset(input bit dis, input bit hard);
        rst_n = 0;
        opt_lp_disable = dis;
        opt_hard_wd = hard;
        ext_irq = '0; ext_irq_en = '0; tmr_irq = 0; idle_stb = 0; cfg_wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] v);
        cfg_wdata = v; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic pulse_idle();
        idle_stb = 1;
        @(negedge clk);
        idle_stb = 0;
    endtask

    task automatic pulse_tmr();
        tmr_irq = 1;
        @(negedge clk);
        tmr_irq = 0;
    endtask

    task automatic pulse_ext(input int idx, input bit en);
        ext_irq_en[idx] = en; ext_irq[idx] = 1;
        @(negedge clk);
        ext_irq[idx] = 0; ext_irq_en[idx] = 0;
    endtask

    task automatic wait_run();
        for (int i = 0; i < 64; i++) begin
            if (pwr_state == 3'd0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        do_reset(0, 0);
        chk("R1 state", int'(pwr_state), 0);
        chk("R1 rdata", int'(cfg_rdata), 0);
        chk("R1 profile", int'({cpu_stop, periph_clk_en, tmr_clk_en, osc_stop, wd_clk_inhibit, clk_restart}), 6'b011000);

        // STANDBY
        cfg_write(3'b001);
        chk("R2 rdata", int'(cfg_rdata), 1);
        pulse_idle();
        chk("R5 standby", int'(pwr_state), 2);
        chk("R6 standby tmr_clk_en", int'(tmr_clk_en), 1);
        chk("R6 standby periph", int'(periph_clk_en), 0);
        chk("R6 standby wd inhibit", int'(wd_clk_inhibit), 1);
        pulse_idle();
        chk("R13 stray idle", int'(pwr_state), 2);
        pulse_tmr();
        chk("R8 tmr wake", int'(pwr_state), 0);
        pulse_idle();
        pulse_ext(2, 1);
        chk("R8 ext wake", int'(pwr_state), 0);

        // HALT
        cfg_write(3'b011);
        pulse_idle();
        chk("R5 halt", int'(pwr_state), 3);
        chk("R6 halt osc_stop", int'(osc_stop), 1);
        pulse_tmr();
        chk("R9 tmr ignored", int'(pwr_state), 3);
        pulse_ext(1, 0);
        chk("R9 disabled ext ignored", int'(pwr_state), 3);
        pulse_ext(1, 1);
        chk("R12 restart entry", int'(pwr_state), 4);
        hi = 0;
        for (int i = 0; i < 4 * RC; i++) begin
            if (clk_restart) hi++;
            else break;
            @(negedge clk);
        end
        chk("R12 restart length", hi, RC);
        chk("R12 back to run", int'(pwr_state), 0);

        // IDLE
        cfg_write(3'b000);
        pulse_idle();
        chk("R5 idle", int'(pwr_state), 1);
        chk("R6 idle cpu_stop", int'(cpu_stop), 1);
        pulse_ext(2, 0);
        chk("R7 disabled ext", int'(pwr_state), 1);
        pulse_ext(2, 1);
        chk("R7 enabled ext", int'(pwr_state), 0);

        // pending wake
        cfg_write(3'b001);
        tmr_irq = 1;
        pulse_idle();
        chk("R11 pending stays run", int'(pwr_state), 0);
        cfg_write(3'b011);
        pulse_idle();
        chk("R11 tmr not halt wake", int'(pwr_state), 3);
        tmr_irq = 0;
        pulse_ext(0, 1);
        wait_run();

        // hard watchdog option
        do_reset(0, 1);
        cfg_write(3'b011);
        pulse_idle();
        pulse_ext(0, 0);
        chk("R10 forced halt wake", int'(pwr_state), 4);
        wait_run();
        cfg_write(3'b001);
        pulse_idle();
        pulse_ext(0, 0);
        chk("R10 forced standby wake", int'(pwr_state), 0);
        cfg_write(3'b000);
        pulse_idle();
        pulse_ext(0, 0);
        chk("R10 idle not forced", int'(pwr_state), 1);
        pulse_tmr();

        // lock
        do_reset(0, 0);
        cfg_write(3'b111);
        chk("R3 lock set", int'(cfg_rdata), 7);
        cfg_write(3'b000);
        chk("R3 locked write ignored", int'(cfg_rdata), 7);
        pulse_idle();
        chk("R3 locked mode still halt", int'(pwr_state), 3);
        pulse_ext(1, 1);
        wait_run();

        // low-power disable
        do_reset(0, 0);
        cfg_write(3'b011);
        opt_lp_disable = 1;
        cfg_write(3'b001);
        chk("R4 write ignored", int'(cfg_rdata), 3);
        pulse_idle();
        chk("R4 forced idle", int'(pwr_state), 1);
        pulse_tmr();
        chk("R7 idle tmr wake", int'(pwr_state), 0);
        opt_lp_disable = 0;
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule